// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank-Switch Controller

This block decodes a 13-bit, 8-bit-data CPU bus for a cartridge that holds a banked ROM and a banked RAM. The upper 2 KB window (0x1800-0x1FFF) always shows the last ROM bank. The lower 2 KB window (0x1000-0x17FF) shows either a selectable 2 KB ROM bank or a selectable 1 KB RAM bank.

The block snoops CPU writes to two low hotspot addresses. A write to 0x003F loads the ROM bank number and returns the window to ROM. A write to 0x003E loads the RAM bank number and switches the window to RAM. In RAM the window is split into two halves. The lower 1 KB half is only read, and the upper 1 KB half is only written. Both halves reach the same RAM bytes.

The ROM and RAM arrays sit outside the block and have combinational read data. The block drives their addresses, the RAM write strobe and write data, and the read data returned to the CPU together with an output enable.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A read in 0x1800-0x1FFF drives `rom_addr_o` = (ROM_BANKS-1)*2048 + addr[10:0] and returns that ROM byte.
- R2: A write to exactly 0x003F loads data into the ROM bank register and leaves RAM mode. A later window read returns the ROM byte at bank*2048 + addr[10:0]. `rom_addr_o[18:11]` holds the bank number.
- R3: If the value written to 0x003F is not below ROM_BANKS, the stored bank is value AND ROM_BANKS. Example with 8 banks: 9 stores 8 and 0x17 stores 0. The ROM array wraps its address modulo its size.
- R4: A write to exactly 0x003E loads the RAM bank register and enters RAM mode. In RAM mode a read in 0x1000-0x13FF returns the RAM byte at bank*1024 + addr[9:0].
- R5: A write in 0x1400-0x17FF stores the data at RAM byte bank*1024 + addr[9:0]. This holds in RAM mode and in ROM mode.
- R6: A write in 0x1000-0x13FF leaves every RAM byte unchanged.
- R7: In RAM mode a read in 0x1400-0x17FF returns 0xFF and also stores 0xFF into the addressed RAM byte.
- R8: After reset both bank registers are 0 and the window is in ROM mode.
- R9: `rdata_oe_o` is 1 exactly for reads at 0x1000 and above. It is 0 for reads below 0x1000 and in every cycle without a read.
- R10: Hotspots match the full 13-bit address with `we_i`. Writes to 0x103F, 0x013E and 0x003D leave the bank registers and the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 13 | CPU address |
| wdata_i | input | 8 | CPU write data |
| we_i | input | 1 | CPU write strobe |
| re_i | input | 1 | CPU read strobe |
| rdata_o | output | 8 | Read data returned to the CPU |
| rdata_oe_o | output | 1 | Read data valid / drive enable |
| rom_addr_o | output | 19 | ROM byte address, {bank, offset} |
| rom_rdata_i | input | 8 | ROM read data (combinational) |
| ram_addr_o | output | 18 | RAM byte address, {bank, offset} |
| ram_we_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data (combinational) |

## Verification
The bench builds the block with ROM_BANKS = 8, which gives a 16 KB ROM. With this size, bank values of 8 and above take the masking path. Value 9 masks to 8, so the masked bank lands outside the ROM and the stored field can be checked on `rom_addr_o`. The RAM model keeps 16 banks, and RAM bank numbers wrap into that space. Directed accesses are followed by a long pseudo-random run. That run mixes hotspot writes with arbitrary bank values, reads and writes on both window halves, and console-range accesses, so mode switches and the unwanted 0xFF write meet earlier data.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam int unsigned AW        = 13;
  localparam int unsigned DW        = 8;
  localparam int unsigned BW        = 8;
  localparam int unsigned ROM_OFF_W = 11;
  localparam int unsigned RAM_OFF_W = 10;
  localparam logic [AW-1:0] HOT_ROM = 13'h003F;
  localparam logic [AW-1:0] HOT_RAM = 13'h003E;

  typedef enum logic [1:0] {
    REG_CONSOLE = 2'd0,
    REG_WIN_RD  = 2'd1,
    REG_WIN_WR  = 2'd2,
    REG_FIXED   = 2'd3
  } region_e;
endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
  import cart_pkg::*;
(
  input  logic [2:0] addr_hi_i,  // addr[12:10]
  output region_e    region_o
);
  always_comb begin
    if (!addr_hi_i[2])     region_o = REG_CONSOLE;
    else if (addr_hi_i[1]) region_o = REG_FIXED;
    else if (addr_hi_i[0]) region_o = REG_WIN_WR;
    else                   region_o = REG_WIN_RD;
  end
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [BW-1:0] rom_bank_o,
  output logic [BW-1:0] ram_bank_o,
  output logic          ram_mode_o
);
  localparam int unsigned CNT_W = BW + 1;

  logic          hit_rom, hit_ram;
  logic [BW-1:0] rom_bank_d;

  assign hit_rom = we_i && (addr_i == HOT_ROM);
  assign hit_ram = we_i && (addr_i == HOT_RAM);

  generate
    if (ROM_BANKS >= (2 ** BW)) begin : g_full
      assign rom_bank_d = wdata_i;
    end else begin : g_mask
      localparam logic [BW-1:0] CNT = BW'(ROM_BANKS);
      // out-of-range request keeps only the bank-count bit
      assign rom_bank_d = ({1'b0, wdata_i} < CNT_W'(ROM_BANKS)) ? wdata_i : (wdata_i & CNT);

      a_r3_bank_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, rom_bank_o} <= CNT_W'(ROM_BANKS));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_bank_o <= '0;
      ram_bank_o <= '0;
      ram_mode_o <= 1'b0;
    end else if (hit_rom) begin
      rom_bank_o <= rom_bank_d;
      ram_mode_o <= 1'b0;
    end else if (hit_ram) begin
      ram_bank_o <= wdata_i;
      ram_mode_o <= 1'b1;
    end
  end

  a_r2_rom_hot_leaves_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_rom |=> !ram_mode_o);
  a_r4_ram_hot_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_ram |=> (ram_mode_o && ram_bank_o == $past(wdata_i)));
  a_r10_no_hot_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i[AW-1:1] == HOT_ROM[AW-1:1]) |=>
      ($stable(rom_bank_o) && $stable(ram_bank_o) && $stable(ram_mode_o)));
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     we_i,
  input  logic                     re_i,
  output logic [DW-1:0]            rdata_o,
  output logic                     rdata_oe_o,
  output logic [BW+ROM_OFF_W-1:0]  rom_addr_o,
  input  logic [DW-1:0]            rom_rdata_i,
  output logic [BW+RAM_OFF_W-1:0]  ram_addr_o,
  output logic                     ram_we_o,
  output logic [DW-1:0]            ram_wdata_o,
  input  logic [DW-1:0]            ram_rdata_i
);
  localparam int unsigned   ROM_AW    = BW + ROM_OFF_W;
  localparam logic [BW-1:0] LAST_BANK = BW'(ROM_BANKS - 1);
  localparam logic [DW-1:0] FILL      = '1;

  region_e       region;
  logic [BW-1:0] rom_bank_q, ram_bank_q;
  logic          ram_mode_q;

  cart_addr_decode u_dec (
    .addr_hi_i (addr_i[AW-1:AW-3]),
    .region_o  (region)
  );

  cart_bank_regs #(.ROM_BANKS(ROM_BANKS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rom_bank_o (rom_bank_q),
    .ram_bank_o (ram_bank_q),
    .ram_mode_o (ram_mode_q)
  );

  always_comb begin
    rom_addr_o  = (region == REG_FIXED) ? {LAST_BANK, addr_i[ROM_OFF_W-1:0]}
                                        : {rom_bank_q, addr_i[ROM_OFF_W-1:0]};
    ram_addr_o  = {ram_bank_q, addr_i[RAM_OFF_W-1:0]};
    ram_we_o    = 1'b0;
    ram_wdata_o = wdata_i;
    rdata_o     = '0;
    rdata_oe_o  = 1'b0;
    unique case (region)
      REG_WIN_RD: if (re_i) begin
        rdata_oe_o = 1'b1;
        rdata_o    = ram_mode_q ? ram_rdata_i : rom_rdata_i;
      end
      REG_WIN_WR: begin
        if (we_i) begin
          ram_we_o = 1'b1;
        end else if (re_i) begin
          rdata_oe_o = 1'b1;
          if (ram_mode_q) begin
            // read of write half disturbs the cell
            rdata_o     = FILL;
            ram_we_o    = 1'b1;
            ram_wdata_o = FILL;
          end else begin
            rdata_o = rom_rdata_i;
          end
        end
      end
      REG_FIXED: if (re_i) begin
        rdata_oe_o = 1'b1;
        rdata_o    = rom_rdata_i;
      end
      default: ;
    endcase
  end

  a_r1_fixed_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[AW-1:AW-2] == 2'b11) |-> (rom_addr_o[ROM_AW-1 -: BW] == LAST_BANK));
  a_r6_no_write_rd_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[AW-1:AW-3] == 3'b100) |-> !ram_we_o);
  a_r7_fill_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_mode_q && re_i && !we_i && addr_i[AW-1:AW-3] == 3'b101) |->
      (ram_we_o && ram_wdata_o == FILL && rdata_o == FILL));
  a_r9_console_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_i[AW-1] || !re_i) |-> !rdata_oe_o);
  a_r5_bus_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
endmodule

// File: tb/cart_bank_ctrl_bench.sv
module cart_bank_ctrl_bench;
  localparam int ROM_BANKS = 8;
  localparam int RAM_BANKS = 16;
  localparam int ROM_SZ    = ROM_BANKS * 2048;
  localparam int RAM_SZ    = RAM_BANKS * 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  rdata, rom_rdata, ram_rdata, ram_wdata;
  logic        rdata_oe, ram_we;
  logic [18:0] rom_addr;
  logic [17:0] ram_addr;

  int vectors = 0, fails = 0;
  bit done = 0;

  logic [7:0] ram_mem [RAM_SZ];
  int         ref_ram [RAM_SZ];
  int         m_rom_bank = 0, m_ram_bank = 0;
  bit         m_ram = 0;

  always #4 clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(ROM_BANKS)) u_cart_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .rdata_oe_o(rdata_oe),
    .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_rdata)
  );

  function automatic int rom_byte(int a);
    return ((a * 13) ^ (a >> 7) ^ (a >> 11)) & 255;
  endfunction

  always_comb rom_rdata = 8'(rom_byte(int'(rom_addr) % ROM_SZ));
  always_comb ram_rdata = ram_mem[int'(ram_addr) % RAM_SZ];
  always @(posedge clk) if (ram_we) ram_mem[int'(ram_addr) % RAM_SZ] <= ram_wdata;

  function automatic int ram_idx(int a);
    return (m_ram_bank * 1024 + (a & 1023)) % RAM_SZ;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (addr %0h)", req, act, exp, addr);
    end
  endtask

  task automatic bus(input int a, input int d, input bit w, input bit r, input string req);
    int exp_d;
    bit exp_oe;
    @(negedge clk);
    addr = 13'(a); wdata = 8'(d); we = w; re = r;
    #1;
    exp_oe = r && (a >= 'h1000);
    exp_d  = 0;
    if (exp_oe) begin
      if (a < 'h1400)      exp_d = m_ram ? ref_ram[ram_idx(a)] : rom_byte((m_rom_bank * 2048 + (a & 2047)) % ROM_SZ);
      else if (a < 'h1800) exp_d = m_ram ? 255 : rom_byte((m_rom_bank * 2048 + (a & 2047)) % ROM_SZ);
      else                 exp_d = rom_byte(((ROM_BANKS - 1) * 2048 + (a & 2047)) % ROM_SZ);
    end
    check(req, int'(rdata_oe), int'(exp_oe));
    if (exp_oe) check(req, int'(rdata), exp_d);
    @(posedge clk);
    if (w) begin
      if (a == 'h3E) begin m_ram = 1; m_ram_bank = d; end
      if (a == 'h3F) begin m_ram = 0; m_rom_bank = (d < ROM_BANKS) ? d : (d & ROM_BANKS); end
      if (a >= 'h1400 && a < 'h1800) ref_ram[ram_idx(a)] = d;
    end else if (r && m_ram && a >= 'h1400 && a < 'h1800) begin
      ref_ram[ram_idx(a)] = 255;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lfsr;
    for (int i = 0; i < RAM_SZ; i++) begin ram_mem[i] = '0; ref_ram[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state: window shows ROM bank 0
    bus('h1000, 0, 0, 1, "R8");
    bus('h17FF, 0, 0, 1, "R8");
    #1 check("R8", int'(rom_addr[18:11]), 0);
    // R1 fixed window
    bus('h1800, 0, 0, 1, "R1");
    bus('h1FFF, 0, 0, 1, "R1");
    bus('h1A55, 0, 0, 1, "R1");
    #1 check("R1", int'(rom_addr), (ROM_BANKS - 1) * 2048 + 'h255);
    // R9 console range and idle
    bus('h0080, 0, 0, 1, "R9");
    bus('h1200, 0, 0, 0, "R9");
    // R2 ROM bank select
    bus('h003F, 3, 1, 0, "R2");
    bus('h1000, 0, 0, 1, "R2");
    bus('h1234, 0, 0, 1, "R2");
    #1 check("R2", int'(rom_addr[18:11]), 3);
    bus('h003F, 7, 1, 0, "R2");
    bus('h17FF, 0, 0, 1, "R2");
    // R3 out-of-range bank masking
    bus('h003F, 9, 1, 0, "R3");
    bus('h1010, 0, 0, 1, "R3");
    #1 check("R3", int'(rom_addr[18:11]), 8);
    bus('h003F, 'h17, 1, 0, "R3");
    bus('h1010, 0, 0, 1, "R3");
    #1 check("R3", int'(rom_addr[18:11]), 0);
    // R4/R5 RAM mode
    bus('h003E, 2, 1, 0, "R4");
    bus('h1405, 'hA5, 1, 0, "R5");
    bus('h1005, 0, 0, 1, "R4");
    bus('h003E, 5, 1, 0, "R4");
    bus('h17FF, 'h3C, 1, 0, "R5");
    bus('h13FF, 0, 0, 1, "R4");
    bus('h003E, 2, 1, 0, "R4");
    bus('h1005, 0, 0, 1, "R4");
    // R6 write to read half ignored
    bus('h1005, 'h11, 1, 0, "R6");
    bus('h1005, 0, 0, 1, "R6");
    // R7 read of write half
    bus('h1406, 0, 0, 1, "R7");
    bus('h1006, 0, 0, 1, "R7");
    // R5 write half stores in ROM mode
    bus('h003F, 1, 1, 0, "R5");
    bus('h1410, 'h77, 1, 0, "R5");
    bus('h1010, 0, 0, 1, "R5");
    bus('h003E, 2, 1, 0, "R5");
    bus('h1010, 0, 0, 1, "R5");
    // R10 near-miss hotspots
    bus('h103F, 5, 1, 0, "R10");
    bus('h013E, 6, 1, 0, "R10");
    bus('h003D, 4, 1, 0, "R10");
    bus('h1010, 0, 0, 1, "R10");
    bus('h1410, 0, 0, 1, "R10");
    // mixed pseudo-random traffic, all requirements
    lfsr = 'h1ACE;
    for (int i = 0; i < 3000; i++) begin
      int a, d, k;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0);
      k = lfsr & 15;
      d = (lfsr >> 4) & 255;
      a = 'h1000 + ((lfsr * 7 + i) & 'hFFF);
      if (k == 0)      bus('h003E, d, 1, 0, "R4");
      else if (k == 1) bus('h003F, d, 1, 0, "R3");
      else if (k == 2) bus(a & 'hFFF, d, 0, 1, "R9");
      else if (k < 7)  bus(a, d, 1, 0, "R5");
      else             bus(a, 0, 0, 1, "R2");
    end
    @(negedge clk);
    we = 0; re = 0;
    finish_run();
  end
endmodule